// File: doc/BRIEF.md
# Random Memory Traffic Checker

This block exercises a memory port on its own and checks what the port returns. Each cycle that it is free to issue, it draws a pseudo-random candidate from a 32-bit LFSR. The candidate is a single-byte read or write. It targets one of three address regions, at a line-aligned offset plus the tester's own index, so that several instances sharing a memory each touch a different byte of the same lines. Requests leave on a valid/ready channel. Responses come back on a separate channel that carries the request address and, for reads, the data.

The block keeps a shadow copy of the bytes it can reach. The byte a read should return is taken from the shadow when the read is issued and is compared when the response arrives. A write reaches the shadow only when its response returns. A small table of outstanding requests keeps any address from having more than one request in flight at a time. The block also counts completed reads and writes, stops issuing once a read target is met, and raises a deadlock flag when responses stop arriving.

Top module: `mem_traffic_checker`

## Requirements
- R1: While `rst_n` is low, `req_valid`, `err`, `deadlock` and `done` are 0, and both counters and all error capture fields are 0.
- R2: The LFSR is loaded with `SEED` at reset. It advances one step, `L = (L >> 1) ^ (L[0] ? 32'h80200003 : 0)`, in every cycle in which `done` is 0 and the block is free. The block is free when no request is presented, or when the presented request is accepted in that cycle. A candidate is built from the LFSR value of that cycle. The candidate is issued, with `req_valid` high from the next cycle, unless R6 or R7 drops it.
- R3: The candidate offset is `((L[31:17] mod MEM_BYTES) / LINE_BYTES) * LINE_BYTES + TESTER_ID`. The address is that offset added to `BASE_UC` if uncached, to `BASE_A` if `L[16]` is 1, and to `BASE_B` otherwise. The low log2(LINE_BYTES) address bits therefore always equal `TESTER_ID`.
- R4: A candidate is uncached when `L[15:8] mod 100 < UC_PCT`. `req_uncached` is 1 exactly for requests in the `BASE_UC` region.
- R5: A candidate is a read (`req_write` = 0) when `L[7:0] mod 100 < RD_PCT`, and a write otherwise. The write byte is `L[23:16]`.
- R6: A candidate whose address matches an outstanding request (issued, response not yet seen at the start of the cycle) is dropped. Nothing is issued that cycle, but the LFSR still advances.
- R7: When all `TBL_DEPTH` outstanding slots are occupied at the start of the cycle, the candidate is dropped in the same way as in R6.
- R8: A presented request that is not accepted stays presented with address, direction, data and uncached bit unchanged, and no new candidate is taken until it is accepted.
- R9: A read response whose data differs from the expected byte sets `err`. The first mismatch captures the address in `err_addr`, the returned byte in `err_got` and the expected byte in `err_exp`. The flag and the captured values then hold until reset.
- R10: The expected byte of a read is the shadow value when the read is issued. The shadow starts at zero and takes a write's byte only on that write's response, so a read of a location returns the last write whose response has come back.
- R11: `rd_count` and `wr_count` each increase by one on every read or write response, respectively.
- R12: When `MAX_READS` is non-zero, `done` goes high in the cycle after the read count reaches `MAX_READS`. From then on no new request is issued. A request already presented is still held until it is accepted.
- R13: An idle counter is cleared by each response and otherwise counts cycles. On the edge at which it reaches `STALL_LIMIT`, `deadlock` goes high and stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Port accepts the presented request |
| req_addr | output | ADDR_W | Byte address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_wdata | output | 8 | Write byte |
| req_uncached | output | 1 | Uncached sideband |
| rsp_valid | input | 1 | Response present |
| rsp_addr | input | ADDR_W | Address of the request being completed |
| rsp_rdata | input | 8 | Read data |
| err | output | 1 | Sticky read mismatch flag |
| err_addr | output | ADDR_W | Address of the first mismatch |
| err_got | output | 8 | Byte returned in the first mismatch |
| err_exp | output | 8 | Byte expected in the first mismatch |
| deadlock | output | 1 | Sticky no-response flag |
| done | output | 1 | Read target reached |
| rd_count | output | CNT_W | Completed reads |
| wr_count | output | CNT_W | Completed writes |

## Verification
The assertions check these properties on every cycle: a refused request holds its fields, each address carries the tester index in its low bits, the uncached bit agrees with the region, no two outstanding slots share an address, each response adds exactly one completion, and `err`, `deadlock` and a quiet port after `done` stay as they are. Only the bench scenarios can show the rest. That covers the exact candidate sequence and which candidates are dropped for a duplicate address or a full table. It also covers the shadow ordering of writes against later reads under out-of-order responses, the capture of an injected mismatch, the exact cycle in which `done` rises, and the cycle in which the watchdog trips.

// File: rtl/mem_traffic_checker.sv
module mem_traffic_checker #(
  parameter int          ADDR_W      = 24,
  parameter int          LINE_BYTES  = 64,
  parameter int          MEM_BYTES   = 4096,
  parameter int          TESTER_ID   = 0,
  parameter int          RD_PCT      = 50,
  parameter int          UC_PCT      = 10,
  parameter int          MAX_READS   = 0,
  parameter int          STALL_LIMIT = 500000,
  parameter int          TBL_DEPTH   = 8,
  parameter int          CNT_W       = 32,
  parameter logic [31:0] SEED        = 32'h1F2E_3D4C,
  parameter logic [23:0] BASE_A      = 24'h100000,
  parameter logic [23:0] BASE_B      = 24'h400000,
  parameter logic [23:0] BASE_UC     = 24'h800000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write,
  output logic [7:0]        req_wdata,
  output logic              req_uncached,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [7:0]        rsp_rdata,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr,
  output logic [7:0]        err_got,
  output logic [7:0]        err_exp,
  output logic              deadlock,
  output logic              done,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  wr_count
);

  localparam int LINES    = MEM_BYTES / LINE_BYTES;
  localparam int SH_DEPTH = 3 * LINES;
  localparam int SH_W     = $clog2(SH_DEPTH);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int TBL_W    = $clog2(TBL_DEPTH);
  localparam int IDLE_W   = $clog2(STALL_LIMIT + 1);
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic [31:0] lfsr;
  logic [31:0] lfsr_nx;
  logic        free, gen, issue;

  assign lfsr_nx = {1'b0, lfsr[31:1]} ^ (lfsr[0] ? TAPS : 32'h0);
  assign free    = !req_valid || req_ready;
  assign gen     = free && !done;

  logic [7:0]        cmd_roll, uc_roll;
  logic [31:0]       off_raw, line_idx;
  logic              c_read, c_uc;
  logic [1:0]        c_region;
  logic [ADDR_W-1:0] c_base, c_addr;
  logic [SH_W-1:0]   c_sidx;

  assign cmd_roll = lfsr[7:0] % 8'd100;
  assign uc_roll  = lfsr[15:8] % 8'd100;
  assign c_read   = cmd_roll < 8'(RD_PCT);
  assign c_uc     = uc_roll < 8'(UC_PCT);
  assign off_raw  = {17'd0, lfsr[31:17]} % 32'(MEM_BYTES);
  assign line_idx = off_raw / 32'(LINE_BYTES);

  always_comb begin
    if (c_uc) begin
      c_base   = ADDR_W'(BASE_UC);
      c_region = 2'd2;
    end else if (lfsr[16]) begin
      c_base   = ADDR_W'(BASE_A);
      c_region = 2'd0;
    end else begin
      c_base   = ADDR_W'(BASE_B);
      c_region = 2'd1;
    end
  end

  assign c_addr = c_base + ADDR_W'(line_idx * 32'(LINE_BYTES) + 32'(TESTER_ID));
  assign c_sidx = SH_W'(32'(c_region) * 32'(LINES) + line_idx);

  logic [TBL_DEPTH-1:0] t_vld;
  logic [ADDR_W-1:0]    t_addr [TBL_DEPTH];
  logic                 t_wr   [TBL_DEPTH];
  logic [7:0]           t_dat  [TBL_DEPTH];
  logic [SH_W-1:0]      t_sidx [TBL_DEPTH];
  logic [TBL_DEPTH-1:0] c_hit, r_hit;

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_cam
    assign c_hit[g] = t_vld[g] && (t_addr[g] == c_addr);
    assign r_hit[g] = t_vld[g] && (t_addr[g] == rsp_addr);
  end

  logic [TBL_W-1:0] slot, r_idx;
  logic             slot_ok;

  always_comb begin
    slot    = '0;
    slot_ok = 1'b0;
    for (int i = TBL_DEPTH - 1; i >= 0; i--) begin
      if (!t_vld[i]) begin
        slot    = TBL_W'(i);
        slot_ok = 1'b1;
      end
    end
  end

  always_comb begin
    r_idx = '0;
    for (int i = 0; i < TBL_DEPTH; i++) begin
      if (r_hit[i]) r_idx = TBL_W'(i);
    end
  end

  assign issue = gen && !(|c_hit) && slot_ok;

  logic [7:0] shadow [SH_DEPTH];
  logic       r_any, r_wr, r_bad;
  logic [7:0] r_exp;
  logic [CNT_W-1:0] rd_nx;

  assign r_any = rsp_valid && (|r_hit);
  assign r_wr  = t_wr[r_idx];
  assign r_exp = t_dat[r_idx];
  assign r_bad = r_any && !r_wr && (rsp_rdata != r_exp);
  assign rd_nx = rd_count + CNT_W'(r_any && !r_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr         <= SEED;
      req_valid    <= 1'b0;
      req_addr     <= '0;
      req_write    <= 1'b0;
      req_wdata    <= '0;
      req_uncached <= 1'b0;
    end else begin
      if (gen) lfsr <= lfsr_nx;
      if (free) req_valid <= issue;
      if (issue) begin
        req_addr     <= c_addr;
        req_write    <= !c_read;
        req_wdata    <= lfsr[23:16];
        req_uncached <= c_uc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_vld <= '0;
      for (int i = 0; i < TBL_DEPTH; i++) begin
        t_addr[i] <= '0;
        t_wr[i]   <= 1'b0;
        t_dat[i]  <= '0;
        t_sidx[i] <= '0;
      end
    end else begin
      if (r_any) t_vld[r_idx] <= 1'b0;
      if (issue) begin
        t_vld[slot]  <= 1'b1;
        t_addr[slot] <= c_addr;
        t_wr[slot]   <= !c_read;
        t_dat[slot]  <= c_read ? shadow[c_sidx] : lfsr[23:16];
        t_sidx[slot] <= c_sidx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SH_DEPTH; i++) shadow[i] <= '0;
    end else if (r_any && r_wr) begin
      shadow[t_sidx[r_idx]] <= r_exp;
    end
  end

  logic [IDLE_W-1:0] idle, idle_nx;

  assign idle_nx = rsp_valid ? '0 :
                   (idle == IDLE_W'(STALL_LIMIT)) ? idle : idle + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle     <= '0;
      deadlock <= 1'b0;
      err      <= 1'b0;
      err_addr <= '0;
      err_got  <= '0;
      err_exp  <= '0;
      rd_count <= '0;
      wr_count <= '0;
      done     <= 1'b0;
    end else begin
      idle     <= idle_nx;
      deadlock <= deadlock || (idle_nx == IDLE_W'(STALL_LIMIT));
      rd_count <= rd_nx;
      wr_count <= wr_count + CNT_W'(r_any && r_wr);
      done     <= done || ((MAX_READS != 0) && (rd_nx >= CNT_W'(MAX_READS)));
      if (r_bad && !err) begin
        err      <= 1'b1;
        err_addr <= rsp_addr;
        err_got  <= rsp_rdata;
        err_exp  <= r_exp;
      end
    end
  end

  AST_HELD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
      && $stable(req_wdata) && $stable(req_uncached)); // R8

  AST_OWN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[LINE_LSB-1:0] == LINE_LSB'(TESTER_ID)); // R3

  AST_UC_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_uncached == (req_addr >= ADDR_W'(BASE_UC))); // R4

  AST_RSP_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> |r_hit); // R6

  for (genvar a = 0; a < TBL_DEPTH; a++) begin : g_uniq_a
    for (genvar b = a + 1; b < TBL_DEPTH; b++) begin : g_uniq_b
      AST_NO_DUP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_vld[a] && t_vld[b] && t_addr[a] == t_addr[b])); // R6
    end
  end

  AST_ONE_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (rd_count + wr_count) == ($past(rd_count) + $past(wr_count) + 1'b1)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && $stable(err_addr) && $stable(err_got) && $stable(err_exp)); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done && !req_valid |=> !req_valid); // R12

  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock); // R13

endmodule

// File: tb/sim_mem_traffic_checker.sv
`timescale 1ns/1ps
module sim_mem_traffic_checker;
  localparam int LINEB = 16, MEMB = 256, ID = 5, RD = 60, UC = 25;
  localparam int MAXR = 400, STALL = 64, DEPTH = 8;
  localparam logic [31:0] SEED = 32'hC0DE_1234;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, req_uncached;
  logic [23:0] req_addr, rsp_addr, err_addr;
  logic [7:0] req_wdata, rsp_rdata, err_got, err_exp;
  logic rsp_valid, err, deadlock, done;
  logic [31:0] rd_count, wr_count;

  mem_traffic_checker #(.LINE_BYTES(LINEB), .MEM_BYTES(MEMB), .TESTER_ID(ID),
    .RD_PCT(RD), .UC_PCT(UC), .MAX_READS(MAXR), .STALL_LIMIT(STALL),
    .TBL_DEPTH(DEPTH), .SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_uncached(req_uncached), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_rdata(rsp_rdata), .err(err), .err_addr(err_addr), .err_got(err_got),
    .err_exp(err_exp), .deadlock(deadlock), .done(done),
    .rd_count(rd_count), .wr_count(wr_count));

  int vec = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] l);
    return {1'b0, l[31:1]} ^ (l[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic void mk(input logic [31:0] l, output logic [23:0] a,
                             output logic w, output logic [7:0] d, output logic u);
    int off, base;
    w    = !((l[7:0] % 100) < RD);
    u    = (l[15:8] % 100) < UC;
    off  = ((int'(l[31:17]) % MEMB) / LINEB) * LINEB + ID;
    base = u ? 32'h800000 : (l[16] ? 32'h100000 : 32'h400000);
    a    = 24'(base + off);
    d    = l[23:16];
  endfunction

  typedef struct { logic [23:0] a; logic w; logic [7:0] d; } acc_t;
  acc_t q[$];
  bit inset [int];
  logic [7:0] mem [int];

  logic [31:0] lfsr_m;
  int rd_m, wr_m, idle_m;
  bit done_m, dead_m, err_m, inj;
  logic [23:0] ea_m; logic [7:0] eg_m, ee_m;
  bit ev, exp_new, was_held, drop_dup, drop_full, gen_done;
  logic [23:0] ca, ha; logic cw, cu, hw, hu; logic [7:0] cd, hd;
  int n_dup, n_full, n_held, phase, tail;

  task automatic verify();
    string tag;
    tag = was_held ? "R8" : exp_new ? "R2" : drop_dup ? "R6" : drop_full ? "R7" : gen_done ? "R12" : "R2";
    chk(req_valid == ev, tag, req_valid, ev);
    if (ev && exp_new) begin
      chk(req_addr == ca, "R3", req_addr, ca);
      chk(req_uncached == cu, "R4", req_uncached, cu);
      chk(req_write == cw, "R5", req_write, cw);
      if (cw) chk(req_wdata == cd, "R5", req_wdata, cd);
    end
    if (was_held)
      chk(req_addr == ha && req_write == hw && req_wdata == hd && req_uncached == hu,
          "R8", req_addr, ha);
    chk(rd_count == 32'(rd_m), "R11", rd_count, rd_m);
    chk(wr_count == 32'(wr_m), "R11", wr_count, wr_m);
    chk(done == done_m, "R12", done, done_m);
    chk(deadlock == dead_m, "R13", deadlock, dead_m);
    chk(err == err_m, inj ? "R9" : "R10", err, err_m);
    if (err_m) begin
      chk(err_addr == ea_m, "R9", err_addr, ea_m);
      chk(err_got == eg_m, "R9", err_got, eg_m);
      chk(err_exp == ee_m, "R9", err_exp, ee_m);
    end
  endtask

  task automatic plan();
    bit fr, gen;
    if (phase == 0 && done_m && q.size() == 0 && !req_valid) phase = 1;
    if (phase == 1) begin
      tail++;
      if (tail > STALL + 6) finished = 1;
    end
    req_ready = (phase == 0) ? (($urandom % 3) != 0) : 1'b1;
    fr  = !req_valid || req_ready;
    gen = fr && !done_m;
    was_held = !fr;
    if (was_held) begin
      ha = req_addr; hw = req_write; hd = req_wdata; hu = req_uncached; n_held++;
    end
    exp_new = 0; drop_dup = 0; drop_full = 0; gen_done = fr && done_m;
    if (gen) begin
      mk(lfsr_m, ca, cw, cd, cu);
      drop_dup  = inset.exists(int'(ca));
      drop_full = !drop_dup && (inset.num() >= DEPTH);
      if (drop_dup) n_dup++;
      if (drop_full) n_full++;
      exp_new = !drop_dup && !drop_full;
      lfsr_m = step(lfsr_m);
    end
    ev = !fr ? 1'b1 : exp_new;
    if (phase == 0 && q.size() > 0 && ($urandom % 2) == 1) begin
      int k;
      acc_t e;
      logic [7:0] tv, rv;
      k = int'($urandom % q.size());
      e = q[k];
      q.delete(k);
      rsp_valid = 1'b1;
      rsp_addr  = e.a;
      if (e.w) begin
        mem[int'(e.a)] = e.d;
        wr_m++;
        rsp_rdata = 8'h00;
      end else begin
        tv = mem.exists(int'(e.a)) ? mem[int'(e.a)] : 8'h00;
        rv = tv;
        if (!inj && rd_m >= 100) begin
          rv  = tv ^ 8'h5A;
          inj = 1;
          if (!err_m) begin
            err_m = 1; ea_m = e.a; eg_m = rv; ee_m = tv;
          end
        end
        rsp_rdata = rv;
        rd_m++;
      end
      inset.delete(int'(e.a));
      idle_m = 0;
    end else begin
      rsp_valid = 1'b0;
      if (idle_m < STALL) idle_m++;
    end
    if (idle_m >= STALL) dead_m = 1;
    done_m = (MAXR != 0) && (rd_m >= MAXR);
    if (req_valid && req_ready) q.push_back('{req_addr, req_write, req_wdata});
    if (exp_new) inset[int'(ca)] = 1'b1;
  endtask

  initial begin
    rst_n = 0; req_ready = 0; rsp_valid = 0; rsp_addr = '0; rsp_rdata = '0;
    lfsr_m = SEED; rd_m = 0; wr_m = 0; idle_m = 0;
    done_m = 0; dead_m = 0; err_m = 0; inj = 0;
    n_dup = 0; n_full = 0; n_held = 0; phase = 0; tail = 0;
    repeat (4) @(negedge clk);
    chk(req_valid == 0, "R1", req_valid, 0);
    chk(err == 0 && deadlock == 0 && done == 0, "R1", {err, deadlock, done}, 0);
    chk(rd_count == 0 && wr_count == 0, "R1", rd_count + wr_count, 0);
    chk(err_addr == 0 && err_got == 0 && err_exp == 0, "R1", err_addr, 0);
    rst_n = 1;
    for (int cyc = 0; cyc < 60000 && !finished; cyc++) begin
      if (cyc > 0) verify();
      plan();
      @(negedge clk);
    end
    chk(finished, "R12", finished, 1);
    chk(n_dup > 0, "R6", n_dup, 1);
    chk(n_full > 0, "R7", n_full, 1);
    chk(n_held > 0, "R8", n_held, 1);
    chk(inj && err, "R9", err, 1);
    chk(deadlock == 1, "R13", deadlock, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog R12 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule